// File: doc/BRIEF.md
# Conflict-Graph Mutual Exclusion Arbiter

This block grants shared access among N requesters whose incompatibilities are described by a conflict graph. The graph is a symmetric N×N adjacency parameter. The block is not limited to one winner. On every clock it grants the largest set of requests it can build greedily, under one rule: no two requesters joined by a conflict edge may hold grants at the same time. Requesters that do not conflict with each other can hold grants together. Overlapping cliques of conflicts are handled with no special cases.

A grant is sticky. Once issued, it stays high for as long as its request stays high. It drops on the clock after the request falls. A requester that is still waiting and has no conflicting grant standing in its way is granted on the next clock. When several conflicting requesters compete for the same slot, a free-running 16-bit LFSR picks a random starting point each cycle, and new grants are assigned in rotated index order from that point. Every contender therefore has a non-zero chance of winning, and no fixed priority can starve one of them.

Top module: `excl_grant_arbiter`

## Requirements
- R1: While reset is high, all grants are driven low on the next clock, and they stay low until a request is seen after reset is released.
- R2: Two requesters joined by a conflict edge never have their grants high in the same cycle. For the default parameters, the edges form the ring 0–1, 1–2, 2–3, 3–0. Bit i*N+j of the adjacency parameter marks the edge between i and j. Diagonal bits are ignored, and an edge set in either direction counts as set.
- R3: A grant rises only if its request was high at the clock edge that raised it. A grant is never high for a requester whose request was low at the previous edge.
- R4: If a request is low at a clock edge while its grant is high, the grant is low after that edge. This is a one-cycle release.
- R5: If a grant is high and its request is high at a clock edge, the grant is still high after that edge.
- R6: After every clock edge, each requester whose request was high at that edge but is not granted has at least one conflicting neighbour with a high grant.
- R7: If the high requests at an edge contain no conflicting pair, then every one of them is granted after that edge.
- R8: When conflicting requests arrive together, the starting index for new grants is taken each cycle as the LFSR state modulo N. The LFSR never holds the all-zero state, and each contender wins a share of repeated contests.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | N | Request per requester; held high for as long as access is wanted |
| grant_o | output | N | Registered grant per requester; always an independent set of the conflict graph |

## Verification
A corrupted grant register or a mis-ordered greedy scan shows up at the ports within one clock. It appears as two adjacent grants high together, or as a granted requester with no request. It can also appear as a waiting requester that is left unserved although none of its neighbours holds a grant. A release path that is stuck shows up as a grant that survives one cycle past its request. A broken random source appears over many repeated contests as one contender never winning. The sweep applies every pair of request patterns (initial and follow-up) on the 4-node ring and checks each result arithmetically against those rules. A separate run of repeated contests measures each contender's share of wins.

// File: rtl/excl_grant_pkg.sv
package excl_grant_pkg;

    localparam int LFSR_W = 16;
    typedef logic [LFSR_W-1:0] lfsr_t;

    // Galois feedback mask for a maximal-length 16-bit sequence
    localparam lfsr_t LFSR_POLY = 16'hB400;
    localparam lfsr_t LFSR_SEED = 16'hACE1;

    // Role of one requester slot in the current cycle
    typedef enum logic [1:0] {
        SLOT_IDLE = 2'd0,   // no request, no grant
        SLOT_HELD = 2'd1,   // granted and still requesting
        SLOT_WAIT = 2'd2,   // requesting, not yet granted
        SLOT_DROP = 2'd3    // granted, request withdrawn
    } slot_e;

    typedef struct packed {
        logic  req;
        logic  grant;
    } slot_in_t;

    function automatic lfsr_t lfsr_step(input lfsr_t s);
        lfsr_t n;
        n = s >> 1;
        if (s[0]) n = n ^ LFSR_POLY;
        return n;
    endfunction

    function automatic slot_e classify(input slot_in_t s);
        slot_e r;
        case ({s.grant, s.req})
            2'b11:   r = SLOT_HELD;
            2'b01:   r = SLOT_WAIT;
            2'b10:   r = SLOT_DROP;
            default: r = SLOT_IDLE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/excl_grant_lfsr.sv
module excl_grant_lfsr
    import excl_grant_pkg::*;
#(
    parameter lfsr_t SEED = LFSR_SEED
) (
    input  logic  clk,
    input  logic  rst,
    output lfsr_t state_o
);

    lfsr_t state_q;

    always_ff @(posedge clk) begin
        if (rst) state_q <= SEED;
        else     state_q <= lfsr_step(state_q);
    end

    assign state_o = state_q;

    // R8: the random source never locks up in the all-zero state
    p_lfsr_nonzero_r8: assert property (@(posedge clk) disable iff (rst)
        state_q != '0);

endmodule

// File: rtl/excl_grant_rotor.sv
module excl_grant_rotor
    import excl_grant_pkg::*;
#(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  lfsr_t         rand_i,
    output logic [IW-1:0] rot_o
);

    assign rot_o = IW'(int'(rand_i) % N);

    // R8: the rotation always names a real requester
    always_comb begin
        p_rot_in_range_r8: assert (int'(rot_o) < N);
    end

endmodule

// File: rtl/excl_grant_pick.sv
module excl_grant_pick
    import excl_grant_pkg::*;
#(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [IW-1:0]         rot_i,
    input  logic [N-1:0]          req_i,
    input  logic [N-1:0]          grant_i,
    input  logic [N-1:0][N-1:0]   nbr_i,
    output logic [N-1:0]          next_o
);

    slot_e             role [N];
    logic [N-1:0]      taken;
    logic [IW-1:0]     idx;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            role[i] = classify('{req: req_i[i], grant: grant_i[i]});
        end
        // Standing grants keep their place first
        taken = '0;
        for (int i = 0; i < N; i++) begin
            if (role[i] == SLOT_HELD) taken[i] = 1'b1;
        end
        // Waiting requesters in rotated order, greedy independent set
        idx = '0;
        for (int k = 0; k < N; k++) begin
            idx = IW'((int'(rot_i) + k) % N);
            if (role[idx] == SLOT_WAIT && (nbr_i[idx] & taken) == '0) begin
                taken[idx] = 1'b1;
            end
        end
        next_o = taken;
    end

    // R3: nothing is proposed for a requester that is not asking
    always_comb begin
        p_pick_subset_r3: assert ((next_o & ~req_i) == '0);
    end

endmodule

// File: rtl/excl_grant_arbiter.sv
module excl_grant_arbiter
    import excl_grant_pkg::*;
#(
    parameter int           N        = 4,
    parameter logic [N*N-1:0] CONFLICT = 16'h5A5A,
    parameter lfsr_t        SEED     = LFSR_SEED
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req_i,
    output logic [N-1:0] grant_o
);

    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [N-1:0][N-1:0] nbr;
    lfsr_t               rand_w;
    logic [IW-1:0]       rot_w;
    logic [N-1:0]        next_w;
    logic [N-1:0]        grant_q;

    // Symmetrised adjacency with self-loops removed
    for (genvar gi = 0; gi < N; gi++) begin : g_row
        for (genvar gj = 0; gj < N; gj++) begin : g_col
            if (gi == gj) begin : g_diag
                assign nbr[gi][gj] = 1'b0;
            end else begin : g_off
                assign nbr[gi][gj] = CONFLICT[gi*N+gj] | CONFLICT[gj*N+gi];
            end
        end
    end

    excl_grant_lfsr #(.SEED(SEED)) lfsr_i (
        .clk     (clk),
        .rst     (rst),
        .state_o (rand_w)
    );

    excl_grant_rotor #(.N(N), .IW(IW)) rotor_i (
        .rand_i (rand_w),
        .rot_o  (rot_w)
    );

    excl_grant_pick #(.N(N), .IW(IW)) pick_i (
        .rot_i   (rot_w),
        .req_i   (req_i),
        .grant_i (grant_q),
        .nbr_i   (nbr),
        .next_o  (next_w)
    );

    always_ff @(posedge clk) begin
        if (rst) grant_q <= '0;
        else     grant_q <= next_w;
    end

    assign grant_o = grant_q;

    // R1: reset clears every grant on the next edge
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> grant_q == '0);

    for (genvar ai = 0; ai < N; ai++) begin : g_chk
        // R3: a grant only appears for a requester that asked
        p_rise_needs_req_r3: assert property (@(posedge clk) disable iff (rst)
            (!grant_q[ai] ##1 grant_q[ai]) |-> $past(req_i[ai]));
        // R4: withdrawal releases the grant after one edge
        p_release_r4: assert property (@(posedge clk) disable iff (rst)
            (grant_q[ai] && !req_i[ai]) |=> !grant_q[ai]);
        // R5: a standing grant survives while still requested
        p_hold_r5: assert property (@(posedge clk) disable iff (rst)
            (grant_q[ai] && req_i[ai]) |=> grant_q[ai]);
        // R6: an unserved requester is blocked by a granted neighbour
        p_blocked_r6: assert property (@(posedge clk) disable iff (rst)
            (req_i[ai] && !rst) |=> (grant_q[ai] || (nbr[ai] & grant_q) != '0));
        for (genvar aj = ai + 1; aj < N; aj++) begin : g_pair
            if ((CONFLICT[ai*N+aj] | CONFLICT[aj*N+ai]) == 1'b1) begin : g_edge
                // R2: adjacent requesters never share a grant
                p_indep_r2: assert property (@(posedge clk) disable iff (rst)
                    !(grant_q[ai] && grant_q[aj]));
            end
        end
    end

endmodule

// File: tb/excl_grant_arbiter_tb_top.sv
`timescale 1ns/1ps
module excl_grant_arbiter_tb_top;

    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] req = '0;
    logic [N-1:0] grant;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    excl_grant_arbiter #(.N(N), .CONFLICT(16'h5A5A)) dut_i (
        .clk     (clk),
        .rst     (rst),
        .req_i   (req),
        .grant_o (grant)
    );

    // Ring conflicts: i and j are adjacent when they differ by 1 modulo 4
    function automatic bit adj(input int i, input int j);
        int d;
        d = (i - j + N) % N;
        return (d == 1) || (d == N - 1);
    endfunction

    function automatic bit indep(input logic [N-1:0] v);
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
                if (v[i] && v[j] && adj(i, j)) return 1'b0;
        return 1'b1;
    endfunction

    function automatic bit blocked_ok(input logic [N-1:0] r, input logic [N-1:0] g);
        bit hit;
        for (int i = 0; i < N; i++) begin
            if (r[i] && !g[i]) begin
                hit = 1'b0;
                for (int j = 0; j < N; j++) if (g[j] && adj(i, j)) hit = 1'b1;
                if (!hit) return 1'b0;
            end
        end
        return 1'b1;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [N-1:0] act,
                         input logic [N-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic step(input logic [N-1:0] r);
        req = r;
        @(negedge clk);
    endtask

    initial begin
        logic [N-1:0] g1, g2;
        int win0, win1, both;
        @(negedge clk);
        @(negedge clk);
        check(grant == '0, "R1 reset state", grant, '0);
        rst = 1'b0;
        step('0);
        check(grant == '0, "R1 idle after reset", grant, '0);

        for (int p = 0; p < 16; p++) begin
            for (int q = 0; q < 16; q++) begin
                step('0);
                step(N'(p));
                g1 = grant;
                check((g1 & ~N'(p)) == '0, "R3 first grant subset", g1, N'(p));
                check(indep(g1), "R2 first grant independent", g1, '0);
                check(blocked_ok(N'(p), g1), "R6 first grant maximal", g1, N'(p));
                if (indep(N'(p)))
                    check(g1 == N'(p), "R7 free set fully granted", g1, N'(p));
                step(N'(q));
                g2 = grant;
                check((g1 & N'(q) & ~g2) == '0, "R5 held grant kept", g2, g1 & N'(q));
                check((g1 & ~N'(q) & g2) == '0, "R4 released grant low", g2, g1 & N'(q));
                check((g2 & ~N'(q)) == '0, "R3 second grant subset", g2, N'(q));
                check(indep(g2), "R2 second grant independent", g2, '0);
                check(blocked_ok(N'(q), g2), "R6 second grant maximal", g2, N'(q));
            end
        end

        win0 = 0; win1 = 0; both = 0;
        for (int t = 0; t < 300; t++) begin
            step('0);
            step(4'b0011);
            if (grant == 4'b0001) win0++;
            else if (grant == 4'b0010) win1++;
            else both++;
        end
        check(both == 0, "R8 exactly one contender wins", 4'(both), 4'd0);
        check(win0 >= 20, "R8 contender 0 wins sometimes", 4'(win0 > 15 ? 15 : win0), 4'd15);
        check(win1 >= 20, "R8 contender 1 wins sometimes", 4'(win1 > 15 ? 15 : win1), 4'd15);

        step(4'b0101);
        check(grant == 4'b0101, "R7 opposite corners granted", grant, 4'b0101);
        rst = 1'b1;
        @(negedge clk);
        check(grant == '0, "R1 reset clears live grants", grant, '0);
        rst = 1'b0;
        step('0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule